// File: doc/BRIEF.md
# Frame Preemption Register Block

This block holds the software-visible state for transmit frame preemption in an Ethernet MAC. A plain word-addressed read/write port reaches three words. The control/status word holds a persistent preemption enable, two write-only triggers and four sticky handshake event flags. Each trigger asks the MAC to send a verify or a response mPacket. The classification word holds the mask of preemptable transmit queues and the additional fragment size. The interrupt word holds the interrupt enable and shows which receive queue carries preemptable traffic.

The MAC core reports handshake events as single-cycle pulses, and each pulse sets its flag. Software collects the events by reading the control/status word. That read returns the flags and clears them. The interrupt line is high while any flag is set and the interrupt enable is on. When software switches the interrupt enable from off to on, flags that built up while it was off are dropped, so old masked events cannot raise an interrupt. The datapath and the mPacket framing are outside this block.

Word addresses: 0 is the control/status word, 1 is the classification word, 2 is the interrupt word. Reads of any other address return zero. Read data is combinational from the current state. A read-clear takes effect at the clock edge where the read is presented.

Top module: `fpe_csr_block`

## Requirements
- R1: After reset, all three words read 0, and `irq`, `fp_enable`, both request pulses, `q_mask`, `frag_size` and `pre_rxq` are 0.
- R2: Bit 0 of word 0 is the preemption enable. It reads back as written and drives `fp_enable`.
- R3: Writing 1 to bit 1 of word 0 makes `send_verify` high for exactly the one cycle after the write edge. Bit 1 always reads 0.
- R4: Writing 1 to bit 2 of word 0 makes `send_resp` high for exactly the one cycle after the write edge. Bit 2 always reads 0.
- R5: A pulse on `evt_in[i]` sets flag bit 16+i of word 0, and the flag stays set. The event order is: i=0 verify received, i=1 response received, i=2 verify transmitted, i=3 response transmitted.
- R6: A read of word 0 returns the flags and clears them. Reads of the other words leave the flags unchanged.
- R7: If an event pulse arrives in the same cycle as a read of word 0, that flag is set after the read, while the other flags are cleared.
- R8: Word 1 holds the queue mask in bits 15:8 and the fragment size in bits 1:0, and drives `q_mask` and `frag_size`. All other bits of word 1 read 0.
- R9: A write of word 0 with bit 0 set loads `pre_rxq` with NUM_RXQ-1. This value shows in word 2 at bits 11:8. Clearing the enable leaves `pre_rxq` unchanged.
- R10: `irq` is high exactly when at least one flag is set and the interrupt enable (bit 0 of word 2) is 1.
- R11: A write of word 2 that turns the interrupt enable from 0 to 1 discards the pending flags. A write that leaves the enable at 1 keeps them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of word 0 clears the flags) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| evt_in | input | 4 | Event pulses from the MAC core |
| fp_enable | output | 1 | Preemption enable |
| send_verify | output | 1 | One-cycle request to send a verify mPacket |
| send_resp | output | 1 | One-cycle request to send a response mPacket |
| q_mask | output | 8 | Preemptable transmit queue mask |
| frag_size | output | 2 | Additional fragment size |
| pre_rxq | output | 2 | Receive queue for preemptable traffic |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situations to reach are coincidences at a single clock edge. One is an event pulse landing in the same cycle as the clearing read. The other is flags that built up while the interrupt enable was off, followed by the write that turns it on. The stimulus sets one flag first, then drives a read and a second event on the same edge. A follow-up read confirms that only the second flag survived. For the interrupt case, the bench raises events with the enable off and confirms that `irq` stays low while the flag is visible. It then turns the enable on and confirms that the flag is gone. A repeated enable write made while already enabled shows that the flags are kept in that case.

// File: rtl/fpe_regs_pkg.sv
package fpe_regs_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int QMASK_W = 8;
    localparam int FRAG_W  = 2;
    localparam int EVT_N   = 4;

    localparam logic [ADDR_W-1:0] A_CSR   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CLASS = 4'd1;
    localparam logic [ADDR_W-1:0] A_IRQ   = 4'd2;

    localparam int EN_BIT   = 0;
    localparam int SV_BIT   = 1;
    localparam int SR_BIT   = 2;
    localparam int EVT_LSB  = 16;
    localparam int MASK_LSB = 8;
    localparam int FRAG_LSB = 0;
    localparam int IE_BIT   = 0;
    localparam int RXQ_LSB  = 8;

    typedef struct packed {
        logic               en;
        logic [QMASK_W-1:0] qmask;
        logic [FRAG_W-1:0]  frag;
        logic               ie;
    } fpe_cfg_t;

    function automatic logic [DATA_W-1:0] pack_csr(logic en, logic [EVT_N-1:0] fl);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT] = en;
        w[EVT_LSB +: EVT_N] = fl;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_class(logic [QMASK_W-1:0] m, logic [FRAG_W-1:0] f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MASK_LSB +: QMASK_W] = m;
        w[FRAG_LSB +: FRAG_W] = f;
        return w;
    endfunction
endpackage

// File: rtl/fpe_evt_flags.sv
module fpe_evt_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (evt[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/fpe_cfg_regs.sv
module fpe_cfg_regs
    import fpe_regs_pkg::*;
#(
    parameter int NUM_RXQ = 4,
    parameter int RXQ_W   = (NUM_RXQ > 1) ? $clog2(NUM_RXQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_csr,
    input  logic             wr_class,
    input  logic             wr_irq,
    input  logic [2:0]       csr_bits,
    input  logic [QMASK_W-1:0] mask_in,
    input  logic [FRAG_W-1:0]  frag_in,
    input  logic             ie_in,
    output fpe_cfg_t         cfg,
    output logic             sv_pulse,
    output logic             sr_pulse,
    output logic [RXQ_W-1:0] rxq,
    output logic             ie_rise
);
    localparam logic [RXQ_W-1:0] RXQ_TOP = RXQ_W'(NUM_RXQ - 1);

    assign ie_rise = wr_irq && ie_in && !cfg.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            sv_pulse <= 1'b0;
            sr_pulse <= 1'b0;
            rxq      <= '0;
        end else begin
            sv_pulse <= wr_csr && csr_bits[SV_BIT];
            sr_pulse <= wr_csr && csr_bits[SR_BIT];
            if (wr_csr) begin
                cfg.en <= csr_bits[EN_BIT];
                if (csr_bits[EN_BIT])
                    rxq <= RXQ_TOP;
            end
            if (wr_class) begin
                cfg.qmask <= mask_in;
                cfg.frag  <= frag_in;
            end
            if (wr_irq)
                cfg.ie <= ie_in;
        end
    end
endmodule

// File: rtl/fpe_csr_block.sv
module fpe_csr_block
    import fpe_regs_pkg::*;
#(
    parameter int NUM_RXQ = 4,
    parameter int RXQ_W   = (NUM_RXQ > 1) ? $clog2(NUM_RXQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [EVT_N-1:0]   evt_in,
    output logic               fp_enable,
    output logic               send_verify,
    output logic               send_resp,
    output logic [QMASK_W-1:0] q_mask,
    output logic [FRAG_W-1:0]  frag_size,
    output logic [RXQ_W-1:0]   pre_rxq,
    output logic               irq
);
    fpe_cfg_t          cfg;
    logic [EVT_N-1:0]  flags;
    logic              ie_rise;
    logic              rd_clr;
    logic              wr_csr, wr_class, wr_irq;
    logic              wdata_unused;

    assign wr_csr   = reg_wr && (reg_addr == A_CSR);
    assign wr_class = reg_wr && (reg_addr == A_CLASS);
    assign wr_irq   = reg_wr && (reg_addr == A_IRQ);
    assign rd_clr   = reg_rd && (reg_addr == A_CSR);
    assign wdata_unused = ^{reg_wdata[DATA_W-1:16], reg_wdata[7:3]};

    fpe_cfg_regs #(.NUM_RXQ(NUM_RXQ), .RXQ_W(RXQ_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_csr   (wr_csr),
        .wr_class (wr_class),
        .wr_irq   (wr_irq),
        .csr_bits (reg_wdata[2:0]),
        .mask_in  (reg_wdata[MASK_LSB +: QMASK_W]),
        .frag_in  (reg_wdata[FRAG_LSB +: FRAG_W]),
        .ie_in    (reg_wdata[IE_BIT]),
        .cfg      (cfg),
        .sv_pulse (send_verify),
        .sr_pulse (send_resp),
        .rxq      (pre_rxq),
        .ie_rise  (ie_rise)
    );

    fpe_evt_flags #(.N(EVT_N)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_in),
        .clr   (rd_clr || ie_rise),
        .flags (flags)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CSR:   reg_rdata = pack_csr(cfg.en, flags);
            A_CLASS: reg_rdata = pack_class(cfg.qmask, cfg.frag);
            A_IRQ: begin
                reg_rdata[IE_BIT] = cfg.ie;
                reg_rdata[RXQ_LSB +: RXQ_W] = pre_rxq;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign fp_enable = cfg.en;
    assign q_mask    = cfg.qmask;
    assign frag_size = cfg.frag;
    assign irq       = (|flags) && cfg.ie;
endmodule

// File: rtl/fpe_csr_chk.sv
module fpe_csr_chk
    import fpe_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [EVT_N-1:0]  evt_in,
    input logic [EVT_N-1:0]  flags,
    input logic              ie_q,
    input logic              fp_enable,
    input logic              send_verify,
    input logic              send_resp,
    input logic              irq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == '0 && !fp_enable && !irq));

    // R2
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr && reg_addr == A_CSR) |-> $stable(fp_enable));

    // R3
    verify_req_chk: assert property (@(posedge clk) disable iff (rst)
        send_verify |-> $past(reg_wr && reg_addr == A_CSR && reg_wdata[SV_BIT]));

    // R4
    resp_req_chk: assert property (@(posedge clk) disable iff (rst)
        send_resp |-> $past(reg_wr && reg_addr == A_CSR && reg_wdata[SR_BIT]));

    // R7
    evt_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_in) |=> (|flags));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_CSR && evt_in == '0) |=> (flags == '0));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ie_q && flags != '0));
endmodule

bind fpe_csr_block fpe_csr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .evt_in      (evt_in),
    .flags       (flags),
    .ie_q        (cfg.ie),
    .fp_enable   (fp_enable),
    .send_verify (send_verify),
    .send_resp   (send_resp),
    .irq         (irq)
);

// File: tb/sim_fpe_csr_block.sv
module sim_fpe_csr_block;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  evt_in = '0;
    logic        fp_enable, send_verify, send_resp, irq;
    logic [7:0]  q_mask;
    logic [1:0]  frag_size;
    logic [1:0]  pre_rxq;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fpe_csr_block #(.NUM_RXQ(4)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .fp_enable(fp_enable), .send_verify(send_verify),
        .send_resp(send_resp), .q_mask(q_mask), .frag_size(frag_size),
        .pre_rxq(pre_rxq), .irq(irq)
    );

    // op: 0 write, 1 read and compare, 2 event pulse (data[3:0])
    localparam int NV = 14;
    localparam logic [69:0] VEC [NV] = '{
        {2'd0, 4'd1, 32'h0010_A503, 32'h0},          // R8 write class word, stray bit 20
        {2'd1, 4'd1, 32'h0,         32'h0000_A503},  // R8
        {2'd0, 4'd0, 32'h0000_0001, 32'h0},          // R2 enable
        {2'd1, 4'd0, 32'h0,         32'h0000_0001},  // R2
        {2'd1, 4'd2, 32'h0,         32'h0000_0300},  // R9 rxq = 3
        {2'd2, 4'd0, 32'h5,         32'h0},          // R5 verify rx + verify tx
        {2'd1, 4'd1, 32'h0,         32'h0000_A503},  // R6 other word, no clear
        {2'd1, 4'd0, 32'h0,         32'h0005_0001},  // R5
        {2'd1, 4'd0, 32'h0,         32'h0000_0001},  // R6 cleared
        {2'd2, 4'd0, 32'hA,         32'h0},          // R5 response rx + response tx
        {2'd1, 4'd0, 32'h0,         32'h000A_0001},  // R5
        {2'd0, 4'd0, 32'h0000_0000, 32'h0},          // R9 disable
        {2'd1, 4'd2, 32'h0,         32'h0000_0300},  // R9 rxq held
        {2'd1, 4'd0, 32'h0,         32'h0000_0000}   // R6 R2
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // samples read data before the clearing edge
    task automatic rd(logic [3:0] a, logic [3:0] ev, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; evt_in = ev;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; evt_in = '0;
    endtask

    task automatic pulse(logic [3:0] ev);
        @(negedge clk);
        evt_in = ev;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        chk("R1 irq/outs", {24'h0, irq, fp_enable, send_verify, send_resp, pre_rxq, frag_size},
            32'h0);
        chk("R1 q_mask", {24'h0, q_mask}, 32'h0);
        for (int a = 0; a < 3; a++) begin
            reg_addr = 4'(a);
            #1 chk("R1 word", reg_rdata, 32'h0);
        end

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][69:68])
                2'd0: wr(VEC[i][67:64], VEC[i][63:32]);
                2'd1: begin
                    rd(VEC[i][67:64], 4'h0, d);
                    chk($sformatf("R5/R6/R8/R9 vector %0d", i), d, VEC[i][31:0]);
                end
                default: pulse(VEC[i][35:32]);
            endcase
        end
        chk("R8 ports", {22'h0, q_mask, frag_size}, {22'h0, 8'hA5, 2'd3});
        chk("R9 port", {30'h0, pre_rxq}, 32'd3);

        // R3 verify request pulse
        wr(4'd0, 32'h3);
        chk("R3 pulse high", {30'h0, send_verify, send_resp}, 32'h2);
        chk("R2 fp_enable", {31'h0, fp_enable}, 32'h1);
        @(negedge clk);
        chk("R3 pulse one cycle", {31'h0, send_verify}, 32'h0);
        reg_addr = 4'd0;
        #1 chk("R3 R4 reads zero", reg_rdata, 32'h1);
        // R4 response request pulse
        wr(4'd0, 32'h5);
        chk("R4 pulse high", {30'h0, send_verify, send_resp}, 32'h1);
        @(negedge clk);
        chk("R4 pulse one cycle", {31'h0, send_resp}, 32'h0);

        // R7 event coinciding with clearing read
        pulse(4'h1);
        rd(4'd0, 4'h2, d);
        chk("R7 read value", d, 32'h0001_0001);
        rd(4'd0, 4'h0, d);
        chk("R7 kept flag", d, 32'h0002_0001);

        // R10 interrupt gating
        wr(4'd2, 32'h1);
        chk("R10 idle", {31'h0, irq}, 32'h0);
        pulse(4'h4);
        chk("R10 irq high", {31'h0, irq}, 32'h1);
        rd(4'd0, 4'h0, d);
        chk("R10 irq after read", {31'h0, irq}, 32'h0);
        wr(4'd2, 32'h0);
        pulse(4'h8);
        chk("R10 masked", {31'h0, irq}, 32'h0);
        reg_addr = 4'd0;
        #1 chk("R10 flag visible", reg_rdata, 32'h0008_0001);

        // R11 enable rise discards stale flags
        wr(4'd2, 32'h1);
        chk("R11 irq after rise", {31'h0, irq}, 32'h0);
        reg_addr = 4'd0;
        #1 chk("R11 flags dropped", reg_rdata, 32'h0000_0001);
        pulse(4'h8);
        wr(4'd2, 32'h1);
        chk("R11 rewrite keeps irq", {31'h0, irq}, 32'h1);
        reg_addr = 4'd0;
        #1 chk("R11 flags kept", reg_rdata, 32'h0008_0001);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule